// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block carries out commands that software writes into a hot-plug controller. A one-cycle strobe presents an 8-bit command code together with a 5-bit slot target. The block keeps a small array of slot records. Each record holds a slot state, a power indicator code, an attention indicator code, a latch-open bit and a presence code. The block also keeps the command status flags and a sticky completion flag. Register decoding on the bus side and interrupt signalling belong to the surrounding register file. That file reads the flags and slot fields from this block's outputs.

There are three families of command codes. Slot operations act on a single slot and finish in the strobe cycle. Bus-speed selection accepts only one value. Two all-slot commands first check the whole array and then work through the slots one per clock while busy is high. When a slot goes to disabled while its power indicator reads off, the slot is torn down: it is marked empty, and one-cycle pulses tell the host side to release the device and to latch the slot events.

Top module: `hp_cmd_exec`

## Requirements
- R1: A strobe accepted while busy is low clears the invalid-command and invalid-mode flags before the command acts. A flag that the new command raises wins over this clear.
- R2: The completion flag goes to 1 on the edge where any command finishes, whatever its outcome. `det_clr` clears it. A completion in the same cycle as the clear wins.
- R3: For codes 0x00–0x3F, bits [1:0] give the requested state (0 keep, 1 power-only, 2 enabled, 3 disabled). Bits [3:2] give the power indicator code and bits [5:4] the attention indicator code (0 keep, 1 on, 2 blink, 3 off).
- R4: A slot operation whose target is outside 1..NSLOTS raises invalid-command and changes no slot. A valid target t addresses slot t-1.
- R5: A request for power-only on an enabled slot raises invalid-command and leaves the state and both indicators of that slot unchanged.
- R6: A nonzero indicator code is written to its field. Code 0 leaves the field unchanged.
- R7: The state changes only from disabled (3) to power-only (1) or enabled (2), or from power-only or enabled to disabled. Any other request leaves the state unchanged without an error.
- R8: A transition to disabled made while the power indicator (after this command's update) is off (3) sets latch-open to 1 and presence to 3. On the same edge it raises `free_o` and `evt_set_o` for that slot for one cycle.
- R9: Codes 0x40–0x47 are bus-speed selections. A value of 0 in bits [2:0] is accepted. Any other value raises invalid-mode.
- R10: Codes 0x48 (power-only all) and 0x49 (enable all) raise invalid-command and change nothing when any slot is enabled.
- R11: Otherwise an all-slot command raises busy one edge after the strobe and processes slot i on edge 2+i. A slot with its latch closed receives the requested state with the power indicator on. A slot with its latch open receives only the power indicator off. Busy falls and completion is flagged on edge NSLOTS+1.
- R12: Codes 0x4A–0xFF raise invalid-command and change no slot.
- R13: A strobe that arrives while busy is high is ignored.
- R14: After reset, each slot whose bit is set in INIT_OCC is enabled, with the latch closed, presence 0 and the power indicator on (1). Every other slot is disabled, with the latch open, presence 3 and the power indicator off (3). All attention codes and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code |
| cmd_target | input | 5 | Slot target for slot operations |
| det_clr | input | 1 | Clears the completion flag |
| busy_o | output | 1 | All-slot sweep in progress |
| inv_cmd_o | output | 1 | Invalid-command flag |
| inv_mode_o | output | 1 | Invalid-mode flag |
| cmd_det_o | output | 1 | Sticky completion flag |
| slot_state_o | output | 2*NSLOTS | Slot states, slot i at [2i+1:2i] |
| pwr_led_o | output | 2*NSLOTS | Power indicator codes |
| attn_led_o | output | 2*NSLOTS | Attention indicator codes |
| mrl_open_o | output | NSLOTS | Latch-open bits |
| presence_o | output | 2*NSLOTS | Presence codes |
| free_o | output | NSLOTS | One-cycle device release pulse |
| evt_set_o | output | NSLOTS | One-cycle pulse: latch button, latch and presence events |

## Verification
A slot operation, a bus-speed selection, a rejected command and a flag clear all show their result after the first rising edge following the strobe. An all-slot sweep shows busy after that same edge, the update for slot i after edge 2+i, and completion after edge NSLOTS+1. The bench stamps every expected snapshot with the number of the edge it is due after. It compares each snapshot on the falling edge of exactly that cycle, and it adds one further snapshot to confirm that the pulses have dropped and the state holds.

// File: rtl/hp_cmd_pkg.sv
package hp_cmd_pkg;

  localparam logic [1:0] ST_KEEP     = 2'd0;
  localparam logic [1:0] ST_PWRONLY  = 2'd1;
  localparam logic [1:0] ST_ENABLED  = 2'd2;
  localparam logic [1:0] ST_DISABLED = 2'd3;

  localparam logic [1:0] LED_KEEP  = 2'd0;
  localparam logic [1:0] LED_ON    = 2'd1;
  localparam logic [1:0] LED_BLINK = 2'd2;
  localparam logic [1:0] LED_OFF   = 2'd3;

  localparam logic [1:0] PRES_LOW   = 2'd0;
  localparam logic [1:0] PRES_EMPTY = 2'd3;

  typedef enum logic [1:0] {CK_SLOT, CK_SPEED, CK_ALL, CK_BAD} cmd_kind_e;

  typedef struct packed {
    logic [1:0] state;
    logic [1:0] pwr;
    logic [1:0] attn;
    logic       mrl_open;
    logic [1:0] pres;
  } slot_t;

  typedef struct packed {
    slot_t nxt;
    logic  removed;
  } slot_res_t;

  function automatic cmd_kind_e classify(logic [7:0] code);
    if (code[7:6] == 2'b00)                   return CK_SLOT;
    if (code[7:3] == 5'b01000)                return CK_SPEED;
    if (code == 8'h48 || code == 8'h49)       return CK_ALL;
    return CK_BAD;
  endfunction

  function automatic logic [1:0] op_state(logic [7:0] code);
    return code[1:0];
  endfunction

  function automatic logic [1:0] op_pwr(logic [7:0] code);
    return code[3:2];
  endfunction

  function automatic logic [1:0] op_attn(logic [7:0] code);
    return code[5:4];
  endfunction

  function automatic logic is_reject(logic [1:0] cur, logic [1:0] req);
    return (cur == ST_ENABLED) && (req == ST_PWRONLY);
  endfunction

  function automatic slot_res_t slot_apply(slot_t cur, logic [1:0] req,
                                           logic [1:0] pw, logic [1:0] at);
    slot_res_t r;
    r.nxt     = cur;
    r.removed = 1'b0;
    if (pw != LED_KEEP) r.nxt.pwr  = pw;
    if (at != LED_KEEP) r.nxt.attn = at;
    if (cur.state == ST_DISABLED && (req == ST_PWRONLY || req == ST_ENABLED)) begin
      r.nxt.state = req;
    end else if ((cur.state == ST_ENABLED || cur.state == ST_PWRONLY) &&
                 req == ST_DISABLED) begin
      r.nxt.state = ST_DISABLED;
      if (r.nxt.pwr == LED_OFF) begin
        r.nxt.mrl_open = 1'b1;
        r.nxt.pres     = PRES_EMPTY;
        r.removed      = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic slot_t reset_slot(logic occupied);
    slot_t s;
    s.attn = LED_KEEP;
    if (occupied) begin
      s.state = ST_ENABLED;  s.pwr = LED_ON;  s.mrl_open = 1'b0; s.pres = PRES_LOW;
    end else begin
      s.state = ST_DISABLED; s.pwr = LED_OFF; s.mrl_open = 1'b1; s.pres = PRES_EMPTY;
    end
    return s;
  endfunction

endpackage

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
  import hp_cmd_pkg::*;
#(
  parameter int                NSLOTS   = 4,
  parameter logic [NSLOTS-1:0] INIT_OCC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOTS-1:0] wr_en,
  input  slot_t             wr_val,
  input  logic              wr_rm,
  output slot_t             slot_q [NSLOTS],
  output logic [NSLOTS-1:0] free_q,
  output logic [NSLOTS-1:0] evt_q
);

  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    slot_t slot_r;
    logic  free_r;
    logic  evt_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_r <= reset_slot(INIT_OCC[g]);
        free_r <= 1'b0;
        evt_r  <= 1'b0;
      end else begin
        free_r <= wr_en[g] && wr_rm;
        evt_r  <= wr_en[g] && wr_rm;
        if (wr_en[g]) slot_r <= wr_val;
      end
    end

    assign slot_q[g] = slot_r;
    assign free_q[g] = free_r;
    assign evt_q[g]  = evt_r;

    // R8: a release pulse only accompanies an emptied, disabled slot
    p_free_marks_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      free_r |-> (slot_r.mrl_open && slot_r.pres == PRES_EMPTY && slot_r.state == ST_DISABLED))
      else $error("release pulse without empty slot");

    // R8: the release pulse lasts one cycle
    p_free_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      free_r |=> !free_r)
      else $error("release pulse longer than one cycle");

    // R7: an enabled slot never drops straight to power-only
    p_no_en_to_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_r.state == ST_ENABLED) |=> (slot_r.state != ST_PWRONLY))
      else $error("enabled slot moved to power-only");
  end

endmodule

// File: rtl/hp_sweep_ctrl.sv
module hp_sweep_ctrl
  import hp_cmd_pkg::*;
#(
  parameter  int NSLOTS = 4,
  localparam int IW     = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_mode,
  output logic          active,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic [1:0]    req_state
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NSLOTS - 1);

  logic mode_q;

  assign last      = active && (idx == LAST_IDX);
  assign req_state = mode_q ? ST_ENABLED : ST_PWRONLY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      mode_q <= start_mode;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + 1'b1;
    end
  end

  // R11: the sweep index stays inside the slot array
  p_idx_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(idx) < NSLOTS))
    else $error("sweep index out of range");

  // R13: a new sweep never starts over a running one
  p_no_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active)
    else $error("sweep restarted while busy");

endmodule

// File: rtl/hp_cmd_status.sv
module hp_cmd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic begin_cmd,
  input  logic set_icmd,
  input  logic set_imode,
  input  logic finish,
  input  logic det_clr,
  input  logic busy,
  output logic inv_cmd,
  output logic inv_mode,
  output logic cmd_det
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_cmd  <= 1'b0;
      inv_mode <= 1'b0;
      cmd_det  <= 1'b0;
    end else begin
      if (set_icmd)       inv_cmd  <= 1'b1;
      else if (begin_cmd) inv_cmd  <= 1'b0;
      if (set_imode)      inv_mode <= 1'b1;
      else if (begin_cmd) inv_mode <= 1'b0;
      if (finish)         cmd_det  <= 1'b1;
      else if (det_clr)   cmd_det  <= 1'b0;
    end
  end

  // R2: every finishing command leaves the completion flag set
  p_det_on_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> cmd_det)
    else $error("completion flag missing");

  // R13: flags hold while a sweep runs
  p_busy_holds_flags_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(inv_cmd) && $stable(inv_mode)))
    else $error("flags changed during sweep");

endmodule

// File: rtl/hp_cmd_exec.sv
module hp_cmd_exec
  import hp_cmd_pkg::*;
#(
  parameter int                NSLOTS   = 4,
  parameter logic [NSLOTS-1:0] INIT_OCC = 4'b0101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [7:0]            cmd_code,
  input  logic [4:0]            cmd_target,
  input  logic                  det_clr,
  output logic                  busy_o,
  output logic                  inv_cmd_o,
  output logic                  inv_mode_o,
  output logic                  cmd_det_o,
  output logic [2*NSLOTS-1:0]   slot_state_o,
  output logic [2*NSLOTS-1:0]   pwr_led_o,
  output logic [2*NSLOTS-1:0]   attn_led_o,
  output logic [NSLOTS-1:0]     mrl_open_o,
  output logic [2*NSLOTS-1:0]   presence_o,
  output logic [NSLOTS-1:0]     free_o,
  output logic [NSLOTS-1:0]     evt_set_o
);

  localparam int IW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

  slot_t             slots [NSLOTS];
  logic [NSLOTS-1:0] wr_en;
  slot_t             wr_val;
  logic              wr_rm;

  logic              sw_active, sw_last, start_sweep;
  logic [IW-1:0]     sw_idx;
  logic [1:0]        sw_req;

  logic              set_icmd, set_imode, finish;

  // named internal events
  logic              accept;
  cmd_kind_e         kind;
  logic              tgt_ok;
  logic [4:0]        tgt_m1;
  logic [IW-1:0]     sel_idx;
  slot_t             cur_tgt, cur_swp;
  logic              any_en;
  slot_res_t         res;

  assign accept  = cmd_wr && !sw_active;
  assign kind    = classify(cmd_code);
  assign tgt_ok  = (cmd_target != 5'd0) && (int'(cmd_target) <= NSLOTS);
  assign tgt_m1  = cmd_target - 5'd1;
  assign sel_idx = tgt_ok ? tgt_m1[IW-1:0] : '0;
  assign cur_tgt = slots[sel_idx];
  assign cur_swp = slots[sw_idx];
  assign busy_o  = sw_active;

  always_comb begin
    any_en = 1'b0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (slots[i].state == ST_ENABLED) any_en = 1'b1;
    end
  end

  always_comb begin
    wr_en       = '0;
    wr_val      = cur_tgt;
    wr_rm       = 1'b0;
    set_icmd    = 1'b0;
    set_imode   = 1'b0;
    finish      = 1'b0;
    start_sweep = 1'b0;
    res         = '0;
    if (sw_active) begin
      if (cur_swp.mrl_open) res = slot_apply(cur_swp, ST_KEEP, LED_OFF, LED_KEEP);
      else                  res = slot_apply(cur_swp, sw_req, LED_ON, LED_KEEP);
      wr_en[sw_idx] = 1'b1;
      wr_val        = res.nxt;
      wr_rm         = res.removed;
      finish        = sw_last;
    end else if (accept) begin
      unique case (kind)
        CK_SLOT: begin
          finish = 1'b1;
          if (!tgt_ok || is_reject(cur_tgt.state, op_state(cmd_code))) begin
            set_icmd = 1'b1;
          end else begin
            res = slot_apply(cur_tgt, op_state(cmd_code), op_pwr(cmd_code), op_attn(cmd_code));
            wr_en[sel_idx] = 1'b1;
            wr_val         = res.nxt;
            wr_rm          = res.removed;
          end
        end
        CK_SPEED: begin
          finish    = 1'b1;
          set_imode = (cmd_code[2:0] != 3'd0);
        end
        CK_ALL: begin
          if (any_en) begin
            set_icmd = 1'b1;
            finish   = 1'b1;
          end else begin
            start_sweep = 1'b1;
          end
        end
        default: begin
          set_icmd = 1'b1;
          finish   = 1'b1;
        end
      endcase
    end
  end

  hp_slot_bank #(.NSLOTS(NSLOTS), .INIT_OCC(INIT_OCC)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_val (wr_val),
    .wr_rm  (wr_rm),
    .slot_q (slots),
    .free_q (free_o),
    .evt_q  (evt_set_o)
  );

  hp_sweep_ctrl #(.NSLOTS(NSLOTS)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_sweep),
    .start_mode (cmd_code[0]),
    .active     (sw_active),
    .idx        (sw_idx),
    .last       (sw_last),
    .req_state  (sw_req)
  );

  hp_cmd_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .begin_cmd (accept),
    .set_icmd  (set_icmd),
    .set_imode (set_imode),
    .finish    (finish),
    .det_clr   (det_clr),
    .busy      (sw_active),
    .inv_cmd   (inv_cmd_o),
    .inv_mode  (inv_mode_o),
    .cmd_det   (cmd_det_o)
  );

  for (genvar g = 0; g < NSLOTS; g++) begin : g_flat
    assign slot_state_o[2*g +: 2] = slots[g].state;
    assign pwr_led_o[2*g +: 2]    = slots[g].pwr;
    assign attn_led_o[2*g +: 2]   = slots[g].attn;
    assign presence_o[2*g +: 2]   = slots[g].pres;
    assign mrl_open_o[g]          = slots[g].mrl_open;
  end

  // R5: enabled-to-power-only is refused with fields untouched
  p_reject_en_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == CK_SLOT && tgt_ok && cur_tgt.state == ST_ENABLED &&
     op_state(cmd_code) == ST_PWRONLY)
    |=> (inv_cmd_o && $stable(slot_state_o) && $stable(pwr_led_o) && $stable(attn_led_o)))
    else $error("enabled to power-only not refused");

  // R4: out-of-range target changes no slot
  p_bad_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == CK_SLOT && !tgt_ok)
    |=> (inv_cmd_o && $stable(slot_state_o) && $stable(pwr_led_o) && $stable(attn_led_o)))
    else $error("bad target altered a slot");

  // R10: a refused all-slot command never raises busy
  p_all_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == CK_ALL && any_en) |=> (!busy_o && inv_cmd_o))
    else $error("all-slot command ran with an enabled slot");

endmodule

// File: tb/tb_hp_cmd_exec.sv
module tb_hp_cmd_exec;
  localparam int N = 4;
  localparam logic [N-1:0] OCC = 4'b0101;
  localparam int VW = 4 + 11 * N;

  logic clk = 1'b0, rst_n = 1'b0, cmd_wr = 1'b0, det_clr = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic [4:0] cmd_target = 5'd0;
  logic busy_o, inv_cmd_o, inv_mode_o, cmd_det_o;
  logic [2*N-1:0] slot_state_o, pwr_led_o, attn_led_o, presence_o;
  logic [N-1:0] mrl_open_o, free_o, evt_set_o;

  hp_cmd_exec #(.NSLOTS(N), .INIT_OCC(OCC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .cmd_target(cmd_target), .det_clr(det_clr), .busy_o(busy_o),
    .inv_cmd_o(inv_cmd_o), .inv_mode_o(inv_mode_o), .cmd_det_o(cmd_det_o),
    .slot_state_o(slot_state_o), .pwr_led_o(pwr_led_o), .attn_led_o(attn_led_o),
    .mrl_open_o(mrl_open_o), .presence_o(presence_o), .free_o(free_o),
    .evt_set_o(evt_set_o));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;

  typedef struct { int due; string tag; logic [VW-1:0] v; } exp_t;
  exp_t q[$];

  // bench model of the slots, written from the requirements
  logic [1:0] ms [N];
  logic [1:0] mp [N];
  logic [1:0] ma [N];
  logic [1:0] mr [N];
  logic       mm [N];
  logic m_icmd = 1'b0, m_imode = 1'b0, m_det = 1'b0;

  function automatic logic [VW-1:0] model_vec(logic busy, logic [N-1:0] fr);
    logic [2*N-1:0] st, pw, at, pr;
    logic [N-1:0] ml;
    for (int i = 0; i < N; i++) begin
      st[2*i +: 2] = ms[i]; pw[2*i +: 2] = mp[i];
      at[2*i +: 2] = ma[i]; pr[2*i +: 2] = mr[i]; ml[i] = mm[i];
    end
    return {busy, m_icmd, m_imode, m_det, st, pw, at, pr, ml, fr, fr};
  endfunction

  function automatic void push(int due, string tag, logic busy, logic [N-1:0] fr);
    exp_t e;
    e.due = due; e.tag = tag; e.v = model_vec(busy, fr);
    q.push_back(e);
  endfunction

  // returns 1 when the slot is torn down
  function automatic logic m_apply(int i, logic [1:0] req, logic [1:0] pw, logic [1:0] at);
    if (pw != 2'd0) mp[i] = pw;
    if (at != 2'd0) ma[i] = at;
    if (ms[i] == 2'd3 && (req == 2'd1 || req == 2'd2)) ms[i] = req;
    else if ((ms[i] == 2'd1 || ms[i] == 2'd2) && req == 2'd3) begin
      ms[i] = 2'd3;
      if (mp[i] == 2'd3) begin mm[i] = 1'b1; mr[i] = 2'd3; return 1'b1; end
    end
    return 1'b0;
  endfunction

  // monitor: compares each expected snapshot in the cycle it is due
  always @(negedge clk) begin
    exp_t e;
    logic [VW-1:0] act;
    act = {busy_o, inv_cmd_o, inv_mode_o, cmd_det_o, slot_state_o, pwr_led_o,
           attn_led_o, presence_o, mrl_open_o, free_o, evt_set_o};
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.due != cyc || act !== e.v) begin
        errors++;
        $display("FAIL %s cycle=%0d actual=%h expected=%h", e.tag, cyc, act, e.v);
      end
    end
  end

  task automatic do_cmd(logic [7:0] code, logic [4:0] tgt, string tag, bit intrude);
    int base, last;
    logic [N-1:0] fr;
    bit any_en;
    @(negedge clk);
    base = cyc; cmd_wr = 1'b1; cmd_code = code; cmd_target = tgt;
    fr = '0; m_icmd = 1'b0; m_imode = 1'b0; last = base + 1;
    if (code < 8'h40) begin
      if (tgt < 5'd1 || int'(tgt) > N) m_icmd = 1'b1;
      else if (ms[tgt-1] == 2'd2 && code[1:0] == 2'd1) m_icmd = 1'b1;
      else fr[tgt-1] = m_apply(int'(tgt) - 1, code[1:0], code[3:2], code[5:4]);
      m_det = 1'b1; push(last, tag, 1'b0, fr);
    end else if (code < 8'h48) begin
      m_imode = (code[2:0] != 3'd0); m_det = 1'b1; push(last, tag, 1'b0, fr);
    end else if (code == 8'h48 || code == 8'h49) begin
      any_en = 1'b0;
      for (int i = 0; i < N; i++) if (ms[i] == 2'd2) any_en = 1'b1;
      if (any_en) begin
        m_icmd = 1'b1; m_det = 1'b1; push(last, tag, 1'b0, fr);
      end else begin
        push(base + 1, tag, 1'b1, fr);
        for (int i = 0; i < N; i++) begin
          if (!mm[i]) void'(m_apply(i, (code == 8'h49) ? 2'd2 : 2'd1, 2'd1, 2'd0));
          else        void'(m_apply(i, 2'd0, 2'd3, 2'd0));
          if (i == N - 1) m_det = 1'b1;
          last = base + 2 + i;
          push(last, tag, (i < N - 1), fr);
        end
      end
    end else begin
      m_icmd = 1'b1; m_det = 1'b1; push(last, tag, 1'b0, fr);
    end
    push(last + 1, tag, 1'b0, '0);
    @(negedge clk);
    if (intrude) begin
      cmd_code = 8'hFF;  // R13: strobe while busy must be ignored
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    while (cyc <= last + 1) @(negedge clk);
  endtask

  task automatic clear_det(string tag);
    @(negedge clk);
    det_clr = 1'b1; m_det = 1'b0;
    push(cyc + 1, tag, 1'b0, '0);
    @(negedge clk);
    det_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      ms[i] = OCC[i] ? 2'd2 : 2'd3; mp[i] = OCC[i] ? 2'd1 : 2'd3;
      ma[i] = 2'd0; mr[i] = OCC[i] ? 2'd0 : 2'd3; mm[i] = !OCC[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push(cyc + 1, "R14", 1'b0, '0);   // reset state
    @(negedge clk); @(negedge clk);

    do_cmd(8'h48, 5'd0, "R10", 0);    // slots enabled: refused
    clear_det("R2");
    do_cmd(8'h41, 5'd0, "R9", 0);     // nonzero speed
    do_cmd(8'h40, 5'd0, "R1", 0);     // accepted speed, clears invalid-mode
    do_cmd(8'h09, 5'd1, "R5", 0);     // enabled -> power-only refused
    do_cmd(8'h1F, 5'd0, "R4", 0);     // target 0
    do_cmd(8'h1F, 5'd5, "R4", 0);     // target above N
    clear_det("R2");
    do_cmd(8'h1F, 5'd1, "R8", 0);     // disable with power off: teardown
    do_cmd(8'h03, 5'd3, "R7", 0);     // disable, indicator on: no teardown
    do_cmd(8'h20, 5'd3, "R6", 0);     // attention blink only
    do_cmd(8'h49, 5'd0, "R11/R13", 1); // enable-all sweep with stray strobe
    do_cmd(8'h49, 5'd0, "R10", 0);    // slot 2 now enabled: refused
    do_cmd(8'h03, 5'd3, "R7", 0);     // back to disabled
    do_cmd(8'h48, 5'd0, "R11", 0);    // power-only-all sweep
    do_cmd(8'h02, 5'd3, "R7", 0);     // power-only -> enabled ignored
    do_cmd(8'h0F, 5'd3, "R8", 0);     // teardown from power-only
    do_cmd(8'h80, 5'd1, "R12", 0);
    do_cmd(8'h4A, 5'd0, "R12", 0);
    do_cmd(8'h36, 5'd2, "R3", 0);     // enable, power on, attention off

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 pending=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule